// File: doc/BRIEF.md
# Carry-Save Running-Total Accumulator

This block sums a stream of operand words at a high clock rate. It keeps the running total in redundant form, as a partial-sum word and a carry word. The total is never turned back into plain binary inside the feedback loop. On each cycle two new operands go through two 3:2 compressor stages in series, together with the two stored words. Each stage is a row of independent full adders, so the path from register to register is two full-adder levels deep for any word width. This lets the loop keep up with a 32-bit word at 153.6 MHz, where a chain of ripple adders would not.

A separate registered carry-propagate adder turns the stored pair into a binary total when asked. The requester pulses `resolve_req`. The block captures the pair at that edge and presents the binary sum one cycle later with `result_valid`. The resolve path uses two states. `RS_IDLE` moves to `RS_ADD` when a request is sampled. `RS_ADD` stays in `RS_ADD` on another request, otherwise it goes back to `RS_IDLE`. In `RS_ADD` the adder output is registered and the valid flag is raised. Arithmetic is modulo 2^WIDTH, so two's-complement operands accumulate correctly. Carries beyond the top bit are dropped.

Top module: `csa_accum`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `result` is 0 and `result_valid` is 0. A resolve issued before any operand is accepted returns 0.
- R2: On a clock edge with `in_valid` high and `clr` low, the stored total grows by `op_a + op_b` modulo 2^WIDTH.
- R3: On a clock edge with `in_valid` low and `clr` low, the values on `op_a` and `op_b` are ignored and the stored total is unchanged.
- R4: On a clock edge with `clr` high, the stored total becomes 0. Operands presented on that same edge are discarded, even when `in_valid` is high.
- R5: A `resolve_req` sampled high at edge k has this effect at edge k+1: `result` holds the total of all operands accepted before edge k (modulo 2^WIDTH), and `result_valid` is 1.
- R6: `result_valid` is high only on the cycle after an edge that followed a sampled request, and low otherwise. While it is low, `result` keeps its last value.
- R7: Carries out of bit WIDTH-1 are discarded. Repeatedly adding all-ones operands gives the total modulo 2^WIDTH.
- R8: Requests on consecutive edges produce results on consecutive cycles. Each result reflects the total at its own request edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of the running total |
| in_valid | input | 1 | Qualifies `op_a` and `op_b` |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| resolve_req | input | 1 | Capture the running total for conversion |
| result | output | WIDTH | Binary total, registered |
| result_valid | output | 1 | Pulses with each new `result` |

## Verification
The assertions assume that `clr`, `in_valid` and `resolve_req` are known (not X) on every edge after reset is released. The bench drives them from fixed values at every falling edge, so this holds. The assertions also assume that reset lasts at least two edges, so that any two-cycle look-back lands on cleared state. The bench holds reset for four edges. The operand words may take any value, including all ones. The random stimulus draws them across the whole range and mixes in maximum values, so the wrap checks see real carries out of the top bit.

// File: rtl/csa_accum_pkg.sv
package csa_accum_pkg;

    // Resolve-path controller states
    typedef enum logic [0:0] {
        RS_IDLE = 1'b0,
        RS_ADD  = 1'b1
    } rs_state_t;

endpackage

// File: rtl/csa_compress32.sv
// One row of independent full adders: three words in, a sum word and
// a carry word out. The carry word is already shifted up one place
// (zero at bit 0), so the carry out of the top bit is dropped.
module csa_compress32 #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic [WIDTH-1:0] z_i,
    output logic [WIDTH-1:0] sum_o,
    output logic [WIDTH-1:0] carry_o
);

    assign carry_o[0] = 1'b0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign sum_o[i] = x_i[i] ^ y_i[i] ^ z_i[i];
        if (i > 0) begin : g_cy
            assign carry_o[i] = (x_i[i-1] & y_i[i-1]) |
                                (x_i[i-1] & z_i[i-1]) |
                                (y_i[i-1] & z_i[i-1]);
        end
    end

endmodule

// File: rtl/csa_resolve.sv
// Registered carry-propagate conversion of the redundant pair.
module csa_resolve
    import csa_accum_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [WIDTH-1:0] sum_i,
    input  logic [WIDTH-1:0] carry_i,
    output logic [WIDTH-1:0] total_o,
    output logic             valid_o
);

    rs_state_t        state_q, state_d;
    logic [WIDTH-1:0] hold_sum_q, hold_carry_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE: state_d = req_i ? RS_ADD : RS_IDLE;
            RS_ADD:  state_d = req_i ? RS_ADD : RS_IDLE;
            default: state_d = RS_IDLE;
        endcase
    end

    // Capture the pair on request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_sum_q   <= '0;
            hold_carry_q <= '0;
        end else if (req_i) begin
            hold_sum_q   <= sum_i;
            hold_carry_q <= carry_i;
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total_o <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= (state_q == RS_ADD);
            if (state_q == RS_ADD) total_o <= hold_sum_q + hold_carry_q;
        end
    end

    // R5: a sampled request yields a valid result two edges later
    p_valid_after_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |-> ##2 valid_o);

    // R6: no request, no valid pulse
    p_no_spurious_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |-> ##2 !valid_o);

    // R6: result held while not valid
    p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(total_o) || $rose(valid_o));

endmodule

// File: rtl/csa_accum.sv
module csa_accum
    import csa_accum_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             resolve_req,
    output logic [WIDTH-1:0] result,
    output logic             result_valid
);

    logic [WIDTH-1:0] sum_q, carry_q;
    logic [WIDTH-1:0] a_eff, b_eff;
    logic [WIDTH-1:0] s1, c1, s2, c2;

    assign a_eff = in_valid ? op_a : '0;
    assign b_eff = in_valid ? op_b : '0;

    // Stage 1: fold op_a into the stored pair
    csa_compress32 #(.WIDTH(WIDTH)) u_stage1 (
        .x_i    (sum_q),
        .y_i    (carry_q),
        .z_i    (a_eff),
        .sum_o  (s1),
        .carry_o(c1)
    );

    // Stage 2: fold op_b in
    csa_compress32 #(.WIDTH(WIDTH)) u_stage2 (
        .x_i    (s1),
        .y_i    (c1),
        .z_i    (b_eff),
        .sum_o  (s2),
        .carry_o(c2)
    );

    // Redundant-form total register
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sum_q   <= '0;
            carry_q <= '0;
        end else begin
            sum_q   <= s2;
            carry_q <= c2;
        end
    end

    csa_resolve #(.WIDTH(WIDTH)) u_resolve (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (resolve_req),
        .sum_i  (sum_q),
        .carry_i(carry_q),
        .total_o(result),
        .valid_o(result_valid)
    );

    // R4: clear empties the total
    p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (WIDTH'(sum_q + carry_q) == '0));

    // R3: unqualified operands leave the total unchanged
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !in_valid) |=>
            (WIDTH'(sum_q + carry_q) == $past(WIDTH'(sum_q + carry_q))));

    // R2 / R7: total advances by both operands, modulo 2^WIDTH
    p_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && in_valid) |=>
            (WIDTH'(sum_q + carry_q) ==
             $past(WIDTH'(sum_q + carry_q + op_a + op_b))));

    // R5: result equals the total seen at the request edge
    p_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(result_valid) |-> (result == $past(WIDTH'(sum_q + carry_q), 2)));

endmodule

// File: tb/csa_accum_bench.sv
module csa_accum_bench;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] op_a = '0, op_b = '0;
    logic         resolve_req = 1'b0;
    logic [W-1:0] result;
    logic         result_valid;

    always #5 clk = ~clk;

    csa_accum #(.WIDTH(W)) u_csa_accum (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .resolve_req(resolve_req),
        .result(result), .result_valid(result_valid)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    logic [W-1:0] ref_total = '0;
    logic         prev_req = 1'b0;
    logic [W-1:0] prev_snap = '0;
    string        prev_tag = "R5";
    logic [W-1:0] last_result = '0;

    function automatic logic [W-1:0] next_total(logic [W-1:0] t, logic c,
                                                logic v, logic [W-1:0] a,
                                                logic [W-1:0] b);
        if (c) return '0;
        if (v) return t + a + b;
        return t;
    endfunction

    task automatic check(string tag, logic [W-1:0] got, logic [W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Called at a falling edge; applies one cycle, checks the outputs
    task automatic cycle(string tag, logic c, logic v, logic [W-1:0] a,
                         logic [W-1:0] b, logic rq);
        logic [W-1:0] snap;
        clr = c; in_valid = v; op_a = a; op_b = b; resolve_req = rq;
        snap = ref_total;
        ref_total = next_total(ref_total, c, v, a, b);
        @(posedge clk);
        @(negedge clk);
        check("R6 valid", {{(W-1){1'b0}}, result_valid}, {{(W-1){1'b0}}, prev_req});
        if (prev_req) begin
            check(prev_tag, result, prev_snap);
            last_result = prev_snap;
        end else begin
            check("R6 hold", result, last_result);
        end
        prev_req = rq; prev_snap = snap; prev_tag = tag;
    endtask

    function automatic logic [W-1:0] rnd_word();
        int unsigned k = $urandom_range(0, 7);
        if (k == 0) return '1;
        return W'($urandom());
    endfunction

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1 result", result, '0);
        check("R1 valid", {{(W-1){1'b0}}, result_valid}, '0);
        rst_n = 1'b1;

        // R1: resolve before any operand
        cycle("R1", 0, 0, '0, '0, 1);
        cycle("R1", 0, 0, '0, '0, 0);

        // R2: simple adds
        cycle("R2", 0, 1, 32'd5, 32'd7, 0);
        cycle("R2", 0, 1, 32'd100, 32'd1, 1);
        cycle("R2", 0, 0, '0, '0, 0);

        // R3: invalid operands ignored
        cycle("R3", 0, 0, 32'hDEAD_BEEF, 32'h1234_5678, 0);
        cycle("R3", 0, 0, '1, '1, 1);
        cycle("R3", 0, 0, '0, '0, 0);

        // R4: clear overrides valid
        cycle("R4", 1, 1, 32'd9, 32'd9, 0);
        cycle("R4", 0, 0, '0, '0, 1);
        cycle("R4", 0, 0, '0, '0, 0);

        // R7: all-ones operands wrap
        for (int i = 0; i < 6; i++) cycle("R7", 0, 1, '1, '1, 0);
        cycle("R7", 0, 1, '1, 32'd1, 1);
        cycle("R7", 0, 0, '0, '0, 0);

        // R8: back-to-back requests
        for (int i = 0; i < 5; i++) cycle("R8", 0, 1, W'(i * 3 + 1), '1, 1);
        cycle("R8", 0, 0, '0, '0, 0);

        // Random mix
        for (int i = 0; i < 600; i++) begin
            cycle("R5", ($urandom_range(0, 29) == 0),
                  ($urandom_range(0, 3) != 0), rnd_word(), rnd_word(),
                  ($urandom_range(0, 3) == 0));
        end
        cycle("R5", 0, 0, '0, '0, 0);

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule